// File: doc/BRIEF.md
# Masked Per-Channel Enable Register

This block is one control word of a multi-channel transfer engine. It stores an on/off bit for each of eight channels and drives those bits straight to the engine. Software reaches it through a simple single-cycle register port: an address-match select, a write strobe, a write data word and a combinational read data word.

Each write carries a paired mask with its data. The low byte holds the new on/off values and the byte above it says which channels the write may touch. Any channel whose mask bit is clear keeps its state. This lets several agents start or stop their own channels without a read-modify-write sequence. When the engine finishes a channel's last beat to its destination, it pulses that channel's completion input. The register then turns the channel off by itself, so software can poll the bit to learn that the transfer is done.

Top module: `chen_enable_reg`

## Requirements
- R1: During and right after a synchronous active-high reset, every channel's enable bit reads 0, so all channels are off.
- R2: A write (select and write strobe both high) in which mask bit 8+i is set loads write data bit i into channel i's enable bit at the next clock edge. A value of 1 turns the channel on and 0 turns it off.
- R3: A write in which mask bit 8+i is clear leaves channel i unchanged. For example, the word 0x0000_0101 turns on channel 0 and leaves channels 1 to 7 as they were.
- R4: A completion pulse on channel i, with no masked write to channel i in the same cycle, clears channel i's enable bit at the next clock edge.
- R5: When a masked write to channel i and a completion pulse on channel i arrive in the same cycle, the write decides the new value.
- R6: A completion pulse on a channel that is already off leaves it off and changes no other channel.
- R7: A write strobe while select is low, or a select without a write strobe, changes no enable bit.
- R8: Read data is combinational. Bits 7:0 are the current enable bits, and bits 31:8, including the mask positions, always read 0.
- R9: Completion pulses and masked writes on different channels in the same cycle each take effect independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Address match for this register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write word: values in bits 7:0, per-channel masks in bits 15:8 |
| reg_rdata | output | 32 | Read word: enable bits in 7:0, zeros above |
| xfer_done | input | 8 | Per-channel completion pulse from the engine |
| chan_on | output | 8 | Per-channel enable to the engine |

## Verification
The checker assumes that select, strobe, write data and completion inputs are clean (never X or Z) at every rising edge outside reset. It also assumes that reset is held from time zero until at least one edge has passed. The bench drives every input to a known value right after each falling edge and keeps reset high for several cycles at the start, so these assumptions hold. The random phase draws completion pulses and masks independently, which means collisions between writes and completions, and pulses on channels already off, occur often. It also drops select or strobe in a share of cycles to exercise ignored writes.

// File: rtl/chen_pkg.sv
package chen_pkg;

    parameter int CH_COUNT  = 8;
    parameter int BUS_WIDTH = 32;

    // Per-channel write intent after decoding one bus cycle
    typedef struct packed {
        logic hit;   // this write may touch the channel
        logic val;   // value to load when hit
    } chan_wr_t;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_LOAD  = 2'd1,
        UPD_CLEAR = 2'd2
    } upd_kind_e;

    // Software write has priority over the completion clear
    function automatic upd_kind_e pick_update(input chan_wr_t wr, input logic done);
        if (wr.hit)
            return UPD_LOAD;
        else if (done)
            return UPD_CLEAR;
        else
            return UPD_HOLD;
    endfunction

endpackage

// File: rtl/chen_write_decode.sv
module chen_write_decode
    import chen_pkg::*;
#(
    parameter int NCH = CH_COUNT,
    parameter int DW  = BUS_WIDTH
) (
    input  logic          sel,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output chan_wr_t      chan_wr [NCH]
);
    localparam int MASK_LSB = NCH;

    logic wr_go;
    assign wr_go = sel & wr;

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign chan_wr[i].hit = wr_go & wdata[MASK_LSB + i];
        assign chan_wr[i].val = wdata[i];
    end
endmodule

// File: rtl/chen_bit_cell.sv
module chen_bit_cell
    import chen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  chan_wr_t wr,
    input  logic     done,
    output logic     on
);
    upd_kind_e kind;
    logic      nxt;

    always_comb begin
        kind = pick_update(wr, done);
        unique case (kind)
            UPD_LOAD:  nxt = wr.val;
            UPD_CLEAR: nxt = 1'b0;
            default:   nxt = on;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            on <= 1'b0;
        else
            on <= nxt;
    end
endmodule

// File: rtl/chen_enable_reg.sv
module chen_enable_reg
    import chen_pkg::*;
#(
    parameter int NCH = CH_COUNT,
    parameter int DW  = BUS_WIDTH
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_sel,
    input  logic           reg_wr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] xfer_done,
    output logic [NCH-1:0] chan_on
);
    localparam int PAD_W = DW - NCH;

    chan_wr_t chan_wr [NCH];

    chen_write_decode #(.NCH(NCH), .DW(DW)) u_dec (
        .sel     (reg_sel),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .chan_wr (chan_wr)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_cell
        chen_bit_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .wr   (chan_wr[i]),
            .done (xfer_done[i]),
            .on   (chan_on[i])
        );
    end

    assign reg_rdata = {{PAD_W{1'b0}}, chan_on};
endmodule

// File: rtl/chen_enable_reg_chk.sv
module chen_enable_reg_chk #(
    parameter int NCH = 8,
    parameter int DW  = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           reg_sel,
    input logic           reg_wr,
    input logic [DW-1:0]  reg_wdata,
    input logic [DW-1:0]  reg_rdata,
    input logic [NCH-1:0] xfer_done,
    input logic [NCH-1:0] chan_on
);
    logic [NCH-1:0] wmask;
    assign wmask = (reg_sel && reg_wr) ? reg_wdata[2*NCH-1:NCH] : '0;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (chan_on == '0));

    // R2
    masked_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wmask != '0) |=> ((chan_on & $past(wmask)) == ($past(reg_wdata[NCH-1:0]) & $past(wmask))));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (wmask == '0 && xfer_done == '0) |=> $stable(chan_on));

    // R4
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ((xfer_done & ~wmask) != '0) |=> ((chan_on & $past(xfer_done & ~wmask)) == '0));

    // R8
    read_zero_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[DW-1:NCH] == '0) && (reg_rdata[NCH-1:0] == chan_on));
endmodule

bind chen_enable_reg chen_enable_reg_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .xfer_done (xfer_done),
    .chan_on   (chan_on)
);

// File: tb/chen_enable_reg_tb.sv
module chen_enable_reg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  xfer_done = '0;
    logic [7:0]  chan_on;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model = '0;

    always #10 clk = ~clk;

    chen_enable_reg u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_done(xfer_done), .chan_on(chan_on)
    );

    function automatic logic [7:0] next_model(input logic [7:0] cur, input logic s,
        input logic w, input logic [31:0] d, input logic [7:0] dn);
        logic [7:0] m;
        m = (s && w) ? d[15:8] : 8'h00;
        return (m & d[7:0]) | (~m & cur & ~dn);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle, then check outputs at the following falling edge
    task automatic cyc(input string req, input logic s, input logic w,
        input logic [31:0] d, input logic [7:0] dn);
        reg_sel = s; reg_wr = w; reg_wdata = d; xfer_done = dn;
        model = next_model(model, s, w, d, dn);
        @(negedge clk);
        check(req, {24'h0, chan_on}, {24'h0, model});
        check(req, reg_rdata, {24'h0, model});
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1", {24'h0, chan_on}, 32'h0);
        rst = 1'b0;
        cyc("R1", 0, 0, 32'h0, 8'h00);
        // R3 0x101 turns on channel 0 only
        cyc("R3", 1, 1, 32'h0000_0101, 8'h00);
        // R2 turn on channels 2 and 5, the 0xFF in value bits is masked
        cyc("R2", 1, 1, 32'h0000_24FF, 8'h00);
        // R2 turn channel 2 off
        cyc("R2", 1, 1, 32'h0000_0400, 8'h00);
        // R7 writes without select or strobe are ignored
        cyc("R7", 0, 1, 32'h0000_FFFF, 8'h00);
        cyc("R7", 1, 0, 32'h0000_FFFF, 8'h00);
        // R4 completion clears channel 5
        cyc("R4", 0, 0, 32'h0, 8'h20);
        // R6 completion on disabled channels has no effect
        cyc("R6", 0, 0, 32'h0, 8'hFE);
        // R5 write wins over completion on channel 3
        cyc("R5", 1, 1, 32'h0000_0808, 8'h08);
        // R9 independent: write channel 7 on, complete channel 0
        cyc("R9", 1, 1, 32'h0000_8080, 8'h01);
        // R2 all channels on, then R8 high read bits zero with mask
        cyc("R2", 1, 1, 32'hFFFF_FFFF, 8'h00);
        check("R8", reg_rdata & 32'hFFFF_FF00, 32'h0);
        cyc("R4", 0, 0, 32'h0, 8'hFF);
        // random phase
        seed = 32'd1234;
        void'($urandom(seed));
        for (int k = 0; k < 400; k++) begin
            cyc("R9", ($urandom % 4) != 0, ($urandom % 4) != 0, $urandom,
                8'($urandom) & 8'($urandom));
        end
        // R1 reset again from a non-zero state
        cyc("R2", 1, 1, 32'h0000_FFFF, 8'h00);
        rst = 1'b1;
        model = '0;
        @(negedge clk);
        check("R1", {24'h0, chan_on}, 32'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule